// File: doc/BRIEF.md
# Serial Test Pattern Sync Detector

This block watches a serial bit stream, qualified by a valid strobe, and locks onto a known test pattern. The pattern is either a fixed word of 1 to 32 bits that repeats end to end, or the output of a linear feedback shift register. Both are described by the same length, tap and contents fields that a matching pattern source would use. An optional inversion complements each received bit before it is compared with anything.

While hunting, the detector predicts each incoming bit and needs 48 correct predictions in a row before it declares sync. Once locked, each mispredicted bit gives a one-cycle error pulse. Errors are counted over back-to-back 48-bit windows, and a window that ends with more than 10 errors drops sync. After a loss the block either starts hunting again by itself or waits for a rising edge on a manual control. A rising edge on that control restarts the hunt at any time. Every change of the sync status also gives a one-cycle event pulse.

Top module: `pattern_sync_det`

## Requirements
- R1: When `cfg_inv` is 1, every received bit is complemented before prediction and comparison, so a complemented stream locks exactly as the plain stream does with `cfg_inv` at 0.
- R2: The pattern length is L = `cfg_len_m1` + 1. In repeat mode (`cfg_prbs` = 0) the expected stream is `cfg_pat[L-1]` down to `cfg_pat[0]`, then it starts again. An aligned stream asserts `sync_o` on the 48th valid bit after hunting starts, and not earlier.
- R3: In shift-register mode (`cfg_prbs` = 1) each expected bit is s[L-1] XOR s[`cfg_tap`]. That bit is shifted into s at bit 0 and is also the transmitted bit. While hunting, s is loaded from the received bits, so a correct stream reaches sync after between 48 and 48+L valid bits.
- R4: In repeat mode, the hunt slips the expected phase by one bit at each mismatch. A stream that starts at any rotation of the word therefore reaches sync within 48+L*L+L valid bits.
- R5: While in sync, each valid bit that differs from the prediction raises `bit_err_o` for one cycle, in the cycle after that bit is sampled. No error pulse appears out of sync.
- R6: While in sync, errors are counted over consecutive 48-bit windows, and the first window starts with the first valid bit after sync is gained. Sync drops only on the last bit of a window that holds 11 or more errors. Ten errors in a window keep sync.
- R7: With `cfg_auto` = 1, hunting restarts on the cycle sync is lost. An aligned stream regains sync 48 valid bits later.
- R8: With `cfg_auto` = 0, sync stays low after a loss for as long as `man_sync` has no rising edge.
- R9: A rising edge on `man_sync` drops sync and restarts the hunt with the bit sampled in that cycle discarded. This takes priority over a hunt completing in the same cycle.
- R10: `sync_chg_o` pulses for exactly one cycle, together with each change of `sync_o`.
- R11: During and just after reset, `sync_o`, `bit_err_o` and `sync_chg_o` are 0 and the block is hunting.
- R12: A cycle with `bit_vld` = 0 changes neither the prediction nor the counters. It raises no error and cannot change sync except through a manual edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prbs | input | 1 | 1 = shift-register pattern, 0 = repeating word |
| cfg_len_m1 | input | 5 | Pattern length minus one |
| cfg_tap | input | 5 | Feedback tap position (shift-register mode) |
| cfg_pat | input | 32 | Repeating word contents (repeat mode) |
| cfg_inv | input | 1 | Complement received bits |
| cfg_auto | input | 1 | Restart hunting automatically after loss |
| man_sync | input | 1 | Manual hunt request, acts on its rising edge |
| bit_in | input | 1 | Serial data |
| bit_vld | input | 1 | Qualifies bit_in |
| sync_o | output | 1 | Sync status |
| bit_err_o | output | 1 | One-cycle pulse per bit error while in sync |
| sync_chg_o | output | 1 | One-cycle pulse on any sync status change |

## Verification
Two cases can land in a single cycle. First, the 11th error of a window can fall on the window's last bit. The bench injects errors on bits 37 to 47 of a window and expects, in the same sampled cycle, an error pulse, sync going low and a change event. Second, a manual rising edge can arrive on the very bit that would complete a hunt. The bench lowers the control on the 47th hunting bit and raises it on the 48th, then expects sync to stay low and to return only 48 valid bits later.

// File: rtl/psd_pkg.sv
package psd_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_LOCK = 2'd1,
    ST_IDLE = 2'd2
  } psd_state_e;

endpackage

// File: rtl/psd_ref.sv
// Local reference: predicts the next received bit for either pattern kind.
module psd_ref #(
  parameter int PAT_W = 32,
  localparam int LW = $clog2(PAT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_prbs,
  input  logic [LW-1:0]    len_m1,
  input  logic [LW-1:0]    tap,
  input  logic [PAT_W-1:0] pat,
  input  logic             rx,
  input  logic             vld,
  input  logic             in_lock,
  input  logic             mism,
  output logic             pred
);

  logic [PAT_W-1:0] sr_q, sr_d, mask;
  logic [LW-1:0]    ph_q, ph_d, pidx;
  logic             fb, rpt_bit;

  for (genvar gi = 0; gi < PAT_W; gi++) begin : g_mask
    assign mask[gi] = (gi <= int'(len_m1));
  end

  always_comb begin
    fb      = sr_q[len_m1] ^ sr_q[tap];
    pidx    = (ph_q > len_m1) ? len_m1 : (len_m1 - ph_q);
    rpt_bit = pat[pidx];
    pred    = cfg_prbs ? fb : rpt_bit;
  end

  always_comb begin
    sr_d = sr_q;
    ph_d = ph_q;
    if (vld) begin
      // hunting seeds from the line, lock free-runs on the prediction
      sr_d = {sr_q[PAT_W-2:0], (in_lock ? fb : rx)} & mask;
      // a mismatch during hunt holds the phase: slips one rotation
      if (in_lock || !mism) begin
        if (ph_q >= len_m1) ph_d = '0;
        else                ph_d = ph_q + LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      ph_q <= '0;
    end else if (vld) begin
      sr_q <= sr_d;
      ph_q <= ph_d;
    end
  end

endmodule

// File: rtl/psd_win.sv
// Hunt run counter and 48-bit lock window error counter.
module psd_win #(
  parameter int WIN_LEN   = 48,
  parameter int ERR_LIMIT = 10,
  localparam int CW = $clog2(WIN_LEN),
  localparam int EW = $clog2(WIN_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic vld,
  input  logic in_lock,
  input  logic mism,
  output logic hunt_done,
  output logic win_fail
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [EW-1:0] err_q, err_d, err_tot;
  logic          last;

  always_comb begin
    last      = (cnt_q == CW'(WIN_LEN - 1));
    err_tot   = err_q + {{(EW-1){1'b0}}, mism};
    hunt_done = !in_lock && vld && !mism && last;
    win_fail  = in_lock && vld && last && (err_tot > EW'(ERR_LIMIT));
  end

  always_comb begin
    cnt_d = cnt_q;
    err_d = err_q;
    if (clr) begin
      cnt_d = '0;
      err_d = '0;
    end else if (vld) begin
      if (in_lock) begin
        cnt_d = last ? '0 : (cnt_q + CW'(1));
        err_d = last ? '0 : err_tot;
      end else begin
        cnt_d = mism ? '0 : (last ? cnt_q : (cnt_q + CW'(1)));
        err_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= '0;
    end else if (clr || vld) begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

endmodule

// File: rtl/psd_fsm.sv
// Hunt / lock / wait control.
module psd_fsm
  import psd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       man_rise,
  input  logic       cfg_auto,
  input  logic       hunt_done,
  input  logic       win_fail,
  output psd_state_e state_q,
  output psd_state_e state_d,
  output logic       clr
);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HUNT: if (hunt_done) state_d = ST_LOCK;
      ST_LOCK: if (win_fail)  state_d = cfg_auto ? ST_HUNT : ST_IDLE;
      ST_IDLE: state_d = ST_IDLE;
      default: state_d = ST_HUNT;
    endcase
    if (man_rise) state_d = ST_HUNT;
    clr = man_rise || (state_d != state_q) || (state_q == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HUNT;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/pattern_sync_det.sv
module pattern_sync_det
  import psd_pkg::*;
#(
  parameter int PAT_W     = 32,
  parameter int WIN_LEN   = 48,
  parameter int ERR_LIMIT = 10,
  localparam int LW = $clog2(PAT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_prbs,
  input  logic [LW-1:0]    cfg_len_m1,
  input  logic [LW-1:0]    cfg_tap,
  input  logic [PAT_W-1:0] cfg_pat,
  input  logic             cfg_inv,
  input  logic             cfg_auto,
  input  logic             man_sync,
  input  logic             bit_in,
  input  logic             bit_vld,
  output logic             sync_o,
  output logic             bit_err_o,
  output logic             sync_chg_o
);

  psd_state_e state_q, state_d;
  logic rx, pred, mism, in_lock, man_q, man_rise;
  logic hunt_done, win_fail, clr;
  logic err_q, chg_q;

  always_comb begin
    rx       = bit_in ^ cfg_inv;
    mism     = rx ^ pred;
    in_lock  = (state_q == ST_LOCK);
    man_rise = man_sync && !man_q;
  end

  psd_ref #(.PAT_W(PAT_W)) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_prbs(cfg_prbs),
    .len_m1  (cfg_len_m1),
    .tap     (cfg_tap),
    .pat     (cfg_pat),
    .rx      (rx),
    .vld     (bit_vld),
    .in_lock (in_lock),
    .mism    (mism),
    .pred    (pred)
  );

  psd_win #(.WIN_LEN(WIN_LEN), .ERR_LIMIT(ERR_LIMIT)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .vld      (bit_vld),
    .in_lock  (in_lock),
    .mism     (mism),
    .hunt_done(hunt_done),
    .win_fail (win_fail)
  );

  psd_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .man_rise (man_rise),
    .cfg_auto (cfg_auto),
    .hunt_done(hunt_done),
    .win_fail (win_fail),
    .state_q  (state_q),
    .state_d  (state_d),
    .clr      (clr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      man_q <= 1'b0;
      err_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      man_q <= man_sync;
      err_q <= in_lock && bit_vld && mism;
      chg_q <= (state_d == ST_LOCK) != in_lock;
    end
  end

  assign sync_o     = in_lock;
  assign bit_err_o  = err_q;
  assign sync_chg_o = chg_q;

endmodule

// File: rtl/psd_chk.sv
module psd_chk
  import psd_pkg::*;
#(
  parameter int WIN_LEN = 48,
  localparam int CW = $clog2(WIN_LEN)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       man_sync,
  input logic       bit_vld,
  input logic       sync_o,
  input logic       bit_err_o,
  input logic       sync_chg_o,
  input psd_state_e state_q
);

  logic          man_d, rise;
  logic [CW-1:0] wpos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      man_d <= 1'b0;
      wpos  <= '0;
    end else begin
      man_d <= man_sync;
      if (!sync_o) wpos <= '0;
      else if (bit_vld) wpos <= (wpos == CW'(WIN_LEN - 1)) ? '0 : wpos + CW'(1);
    end
  end

  assign rise = man_sync && !man_d;

  AST_ERR_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err_o |-> $past(sync_o && bit_vld)); // R5

  AST_CHG_TRACKS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    sync_chg_o == (sync_o != $past(sync_o))); // R10

  AST_MAN_EDGE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !sync_o); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !rise) |=> !sync_o); // R8

  AST_LOSS_AT_WIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && !rise && !(bit_vld && wpos == CW'(WIN_LEN - 1))) |=> sync_o); // R6

  AST_NO_GAIN_IDLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_o && !bit_vld) |=> !sync_o); // R12

endmodule

bind pattern_sync_det psd_chk #(.WIN_LEN(WIN_LEN)) u_psd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .man_sync  (man_sync),
  .bit_vld   (bit_vld),
  .sync_o    (sync_o),
  .bit_err_o (bit_err_o),
  .sync_chg_o(sync_chg_o),
  .state_q   (state_q)
);

// File: tb/test_pattern_sync_det.sv
module test_pattern_sync_det;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_prbs, cfg_inv, cfg_auto, man_sync, bit_in, bit_vld;
  logic [4:0]  cfg_len_m1, cfg_tap;
  logic [31:0] cfg_pat;
  logic        sync_o, bit_err_o, sync_chg_o;

  always #4 clk = ~clk;

  pattern_sync_det i_pattern_sync_det (
    .clk(clk), .rst_n(rst_n), .cfg_prbs(cfg_prbs), .cfg_len_m1(cfg_len_m1),
    .cfg_tap(cfg_tap), .cfg_pat(cfg_pat), .cfg_inv(cfg_inv), .cfg_auto(cfg_auto),
    .man_sync(man_sync), .bit_in(bit_in), .bit_vld(bit_vld),
    .sync_o(sync_o), .bit_err_o(bit_err_o), .sync_chg_o(sync_chg_o)
  );

  // {prbs, len_m1, tap, pattern/seed, inv, start phase}
  localparam logic [48:0] VEC [4] = '{
    {1'b0, 5'd7,  5'd0,  32'h000000B4, 1'b0, 5'd0},
    {1'b0, 5'd7,  5'd0,  32'h000000B4, 1'b1, 5'd5},
    {1'b1, 5'd6,  5'd5,  32'h0000005A, 1'b0, 5'd0},
    {1'b1, 5'd14, 5'd13, 32'h00001234, 1'b1, 5'd0}
  };

  int n_tot = 0, n_bad = 0, n_err = 0, n_chg = 0;
  int g_len, g_tap, g_ph, found, lo, hi, e0, c0;
  logic g_prbs, g_inv, man, s_sync, s_err, s_chg;
  logic [31:0] g_pat, g_st;

  task automatic chk(input string tag, input int act, input int exp);
    n_tot++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int l, input int h);
    n_tot++;
    if (act < l || act > h) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, l, h);
    end
  endtask

  task automatic gen_bit(output logic b);
    logic nb;
    logic [31:0] m;
    if (g_prbs) begin
      m = (g_len == 32) ? 32'hFFFF_FFFF : ((32'd1 << g_len) - 32'd1);
      nb = g_st[g_len-1] ^ g_st[g_tap];
      g_st = ((g_st << 1) | {31'd0, nb}) & m;
      b = nb;
    end else begin
      b = g_pat[g_len-1-g_ph];
      g_ph = (g_ph + 1) % g_len;
    end
  endtask

  task automatic step(input logic v, input logic flip);
    logic b;
    if (v) gen_bit(b);
    else b = ~bit_in;
    @(negedge clk);
    bit_in   = v ? (b ^ g_inv ^ flip) : b;
    bit_vld  = v;
    man_sync = man;
    @(posedge clk);
    #2;
    s_sync = sync_o;
    s_err  = bit_err_o;
    s_chg  = sync_chg_o;
    if (s_err) n_err++;
    if (s_chg) n_chg++;
  endtask

  task automatic hunt(input int bound, output int at);
    at = 0;
    for (int i = 1; i <= bound; i++) begin
      step(1'b1, 1'b0);
      if (s_sync) begin
        at = i;
        break;
      end
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; man = 1'b0; man_sync = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R11 sync in reset", int'(sync_o), 0);
    chk("R11 err in reset", int'(bit_err_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk("R11 chg after reset", int'(sync_chg_o), 0);
    n_err = 0;
    n_chg = 0;
  endtask

  task automatic load(input logic [48:0] v);
    cfg_prbs = v[48]; cfg_len_m1 = v[47:43]; cfg_tap = v[42:38];
    cfg_pat = v[37:6]; cfg_inv = v[5]; cfg_auto = 1'b1;
    g_prbs = v[48]; g_len = int'(v[47:43]) + 1; g_tap = int'(v[42:38]);
    g_pat = v[37:6]; g_st = v[37:6]; g_inv = v[5]; g_ph = int'(v[4:0]);
  endtask

  initial begin
    rst_n = 1'b0;
    load(VEC[0]);
    // table of configurations, one loop
    for (int k = 0; k < 4; k++) begin
      load(VEC[k]);
      do_reset();
      lo = 48;
      if (g_prbs) hi = 48 + g_len;
      else if (g_ph == 0) hi = 48;
      else hi = 48 + g_len * g_len + g_len;
      hunt(hi + 20, found);
      chk_rng(g_prbs ? "R3 lock bits prbs" : (g_ph != 0 ? "R4 lock bits rotated" : "R2 lock bits"),
              found, lo, hi);
      if (g_inv) chk("R1 inverted stream locks", int'(found != 0), 1);
      e0 = n_err;
      for (int i = 0; i < 60; i++) step(1'b1, 1'b0);
      chk("R5 no errors on clean stream", n_err - e0, 0);
      chk("R2 still in sync", int'(s_sync), 1);
      chk("R10 one change event", n_chg, 1);
    end

    // directed: repeat word, automatic resync
    load(VEC[0]);
    do_reset();
    hunt(200, found);
    chk("R2 aligned lock at 48", found, 48);
    e0 = n_err;
    for (int p = 0; p < 48; p++) step(1'b1, p <= 9);
    chk("R5 ten error pulses", n_err - e0, 10);
    chk("R6 ten errors keep sync", int'(s_sync), 1);
    e0 = n_err; c0 = n_chg;
    for (int p = 0; p < 47; p++) step(1'b1, p >= 37);
    chk("R6 sync held before window end", int'(s_sync), 1);
    step(1'b1, 1'b1);
    chk("R6 loss on window end", int'(s_sync), 0);
    chk("R5 error pulse with loss", int'(s_err), 1);
    chk("R10 change on loss", int'(s_chg), 1);
    chk("R5 eleven error pulses", n_err - e0, 11);
    hunt(200, found);
    chk("R7 auto relock at 48", found, 48);

    // manual recovery
    cfg_auto = 1'b0;
    for (int p = 0; p < 47; p++) step(1'b1, p <= 10);
    chk("R6 early errors wait for window end", int'(s_sync), 1);
    step(1'b1, 1'b0);
    chk("R6 loss with auto off", int'(s_sync), 0);
    c0 = n_chg;
    for (int i = 0; i < 150; i++) step(1'b1, 1'b0);
    chk("R8 stays out of sync", int'(s_sync), 0);
    chk("R8 no change events", n_chg - c0, 0);
    man = 1'b1;
    step(1'b1, 1'b0);
    hunt(200, found);
    chk("R9 manual hunt locks at 48", found, 48);

    // manual edge while locked, then on the completing bit
    man = 1'b0;
    step(1'b1, 1'b0);
    c0 = n_chg;
    man = 1'b1;
    step(1'b1, 1'b0);
    chk("R9 edge drops sync", int'(s_sync), 0);
    chk("R10 change on manual drop", n_chg - c0, 1);
    for (int i = 0; i < 46; i++) step(1'b1, 1'b0);
    man = 1'b0;
    step(1'b1, 1'b0);
    man = 1'b1;
    step(1'b1, 1'b0);
    chk("R9 edge beats hunt completion", int'(s_sync), 0);
    hunt(200, found);
    chk("R9 relock after restart", found, 48);

    // idle strobes
    e0 = n_err;
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0);
    chk("R12 no errors without strobe", n_err - e0, 0);
    chk("R12 sync kept without strobe", int'(s_sync), 1);
    for (int i = 0; i < 48; i++) step(1'b1, 1'b0);
    chk("R12 stream resumes aligned", n_err - e0, 0);

    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tot++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

endmodule